// File: doc/BRIEF.md
# Receive-Ring Free-Buffer Pause Trigger

This block sits beside a receive DMA that drains up to eight descriptor rings. For each ring it keeps the index of the next descriptor the hardware will consume and a refill mark that software moves forward each time it hands a fresh buffer back. The distance from the consume index to the refill mark, taken modulo the ring size, is the number of free buffers left on that ring. When any active ring's free count drops under its programmed threshold, the block raises a flow-control request to the transmit MAC. The MAC uses this request to send a PAUSE frame carrying the programmed pause time.

Software first clears the enable bit. It then programs each ring's size and threshold, and the pause time, and sets the enable bit again. At the moment the block becomes enabled, every ring's refill mark is placed one slot behind its consume index, so each ring starts out looking completely free. While the block is enabled, the ring and pause-time settings are frozen, and only refill-mark updates and the enable bit are accepted. A pacing timer makes sure that repeated send pulses are separated by at least one pause window while the shortage lasts.

Top module: `rx_pause_trigger`

## Requirements
- R1: After reset, pause_req and pause_send are 0, pause_time is 4, and every ring has size 0. A ring of size 0 is inactive and never contributes to the request.
- R2: A parameter write carries the ring size in bits [8:0] and the threshold in bits [31:24]. It takes effect only while the block is disabled, and it also clears that ring's consume index and refill mark. A pause-time write likewise takes effect only while disabled. Both kinds of write are ignored while the block is enabled.
- R3: The enable is bit 14 of the control write. When that bit is written to 1 while the block is disabled, each ring's refill mark is set to (consume index − 1) mod size, so the free count becomes size − 1.
- R4: Each cycle that cons_stb is high, the consume index of ring cons_ring advances by one and wraps from size − 1 back to 0. This tracking continues while the block is disabled.
- R5: The free count of a ring is (refill mark − consume index) mod size. A ring is short when its free count is less than its threshold; a free count equal to the threshold is not short. pause_req is 1 exactly when the block is enabled and at least one active ring is short, and it reflects a state change one clock later.
- R6: A refill-mark write sets the mark of ring lfp_ring to lfp_idx. It is accepted only while the block is enabled, and it is ignored when lfp_idx is not smaller than the ring size.
- R7: pause_send is a one-cycle pulse that occurs only while pause_req is 1. The first pulse comes in the same cycle that pause_req rises. While the shortage persists, the next pulse comes pause_time × 64 + 1 cycles later. pause_time always shows the programmed value.
- R8: Writing the enable bit to 0 drops pause_req and pause_send one clock after the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word; bit 14 is the enable |
| prm_we | input | 1 | Ring parameter write strobe |
| prm_ring | input | 3 | Ring selected by the parameter write |
| prm_wdata | input | 32 | Size in [8:0], threshold in [31:24] |
| ptv_we | input | 1 | Pause time write strobe |
| ptv_wdata | input | 16 | Pause time value |
| lfp_we | input | 1 | Refill mark write strobe |
| lfp_ring | input | 3 | Ring selected by the refill mark write |
| lfp_idx | input | 8 | New refill mark index |
| cons_stb | input | 1 | One descriptor consumed this cycle |
| cons_ring | input | 3 | Ring the consumed descriptor belongs to |
| pause_req | output | 1 | Some enabled ring is short of buffers |
| pause_send | output | 1 | Pulse telling the MAC to emit a PAUSE frame |
| pause_time | output | 16 | Pause time to place in the frame |

## Verification
The hardest situation to reach is a short ring whose consume index has already wrapped past the end, while its refill mark sits numerically below the consume index. The stimulus advances a small eight-entry ring before enabling, so the initial refill mark is not at slot zero. It then consumes across the wrap and moves the refill mark backwards in index terms. This makes the modulo distance, not the plain difference, decide whether the request is raised. A second long-lived shortage is held while the bench counts cycles between send pulses. During that shortage it also attempts frozen writes, to show that they change neither the window nor the threshold.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int EN_BIT  = 14;  // enable bit in the control word
  localparam int THR_LSB = 24;  // threshold field start in parameter word
  localparam int DEF_THR = 16;  // reset threshold
  localparam int DEF_PTV = 4;   // reset pause time
endpackage

// File: rtl/rxp_ring_track.sv
module rxp_ring_track
  import rxp_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             init,
  input  logic             prm_we,
  input  logic [IDX_W:0]   prm_size,
  input  logic [THR_W-1:0] prm_thr,
  input  logic             lfp_we,
  input  logic [IDX_W-1:0] lfp_idx,
  input  logic             cons_stb,
  output logic             short_o
);
  logic [IDX_W:0]   size_q;
  logic [THR_W-1:0] thr_q;
  logic [IDX_W-1:0] cons_q, lf_q;
  logic [IDX_W-1:0] cons_nxt, cons_upd, init_lf;
  logic [IDX_W:0]   free;
  logic             active;

  assign active   = (size_q != '0);
  assign cons_nxt = ({1'b0, cons_q} + 1'b1 == size_q) ? '0 : cons_q + 1'b1;
  assign cons_upd = (cons_stb && active) ? cons_nxt : cons_q;
  assign init_lf  = (cons_upd == '0) ? IDX_W'(size_q - 1'b1) : cons_upd - 1'b1;

  always_comb begin
    if (lf_q >= cons_q) free = {1'b0, lf_q} - {1'b0, cons_q};
    else                free = {1'b0, lf_q} + size_q - {1'b0, cons_q};
  end

  assign short_o = active && (32'(free) < 32'(thr_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= '0;
      thr_q  <= THR_W'(DEF_THR);
      cons_q <= '0;
      lf_q   <= '0;
    end else if (prm_we && !en) begin
      size_q <= prm_size;
      thr_q  <= prm_thr;
      cons_q <= '0;
      lf_q   <= '0;
    end else begin
      cons_q <= cons_upd;
      if (init)
        lf_q <= init_lf;
      else if (lfp_we && en && ({1'b0, lfp_idx} < size_q))
        lf_q <= lfp_idx;
    end
  end

  p_param_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    (en && prm_we) |=> ($stable(size_q) && $stable(thr_q)));
  p_cons_range_r4: assert property (@(posedge clk) disable iff (rst)
    (size_q != '0) |-> ({1'b0, cons_q} < size_q));
  p_mark_range_r6: assert property (@(posedge clk) disable iff (rst)
    (size_q != '0) |-> ({1'b0, lf_q} < size_q));
  p_init_full_r3: assert property (@(posedge clk) disable iff (rst)
    (init && !prm_we && size_q != '0) |=> (free == size_q - 1'b1));
endmodule

// File: rtl/rxp_pause_pacer.sv
module rxp_pause_pacer #(
  parameter int PT_W   = 16,
  parameter int QSHIFT = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            short_any,
  input  logic [PT_W-1:0] ptv,
  output logic            pause_req,
  output logic            pause_send
);
  localparam int TW = PT_W + QSHIFT;
  logic [TW-1:0] tmr_q, win, reload;
  logic          fire;

  assign win    = {ptv, {QSHIFT{1'b0}}};
  assign reload = (win == '0) ? TW'(1) : win;
  assign fire   = short_any && (tmr_q == '0);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pause_req  <= 1'b0;
      pause_send <= 1'b0;
      tmr_q      <= '0;
    end else begin
      pause_req  <= short_any;
      pause_send <= fire;
      if (fire)              tmr_q <= reload;
      else if (tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
    end
  end

  p_send_in_req_r7: assert property (@(posedge clk) disable iff (rst)
    pause_send |-> pause_req);
  p_no_back_to_back_r7: assert property (@(posedge clk) disable iff (rst)
    pause_send |=> !pause_send);
  p_off_when_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pause_req && !pause_send));
endmodule

// File: rtl/rx_pause_trigger.sv
module rx_pause_trigger
  import rxp_pkg::*;
#(
  parameter int NUM_RINGS = 8,
  parameter int IDX_W     = 8,
  parameter int THR_W     = 8,
  parameter int PT_W      = 16,
  parameter int QSHIFT    = 6,
  localparam int RID_W    = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [31:0]      ctl_wdata,
  input  logic             prm_we,
  input  logic [RID_W-1:0] prm_ring,
  input  logic [31:0]      prm_wdata,
  input  logic             ptv_we,
  input  logic [PT_W-1:0]  ptv_wdata,
  input  logic             lfp_we,
  input  logic [RID_W-1:0] lfp_ring,
  input  logic [IDX_W-1:0] lfp_idx,
  input  logic             cons_stb,
  input  logic [RID_W-1:0] cons_ring,
  output logic             pause_req,
  output logic             pause_send,
  output logic [PT_W-1:0]  pause_time
);
  logic                 en_q, init;
  logic [PT_W-1:0]      ptv_q;
  logic [NUM_RINGS-1:0] short_vec;
  logic                 unused_bits;

  assign unused_bits = ^{ctl_wdata, prm_wdata};
  assign init        = ctl_we && ctl_wdata[EN_BIT] && !en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      ptv_q <= PT_W'(DEF_PTV);
    end else begin
      if (ctl_we)           en_q  <= ctl_wdata[EN_BIT];
      if (ptv_we && !en_q)  ptv_q <= ptv_wdata;
    end
  end
  assign pause_time = ptv_q;

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
    rxp_ring_track #(.IDX_W(IDX_W), .THR_W(THR_W)) u_trk (
      .clk      (clk),
      .rst      (rst),
      .en       (en_q),
      .init     (init),
      .prm_we   (prm_we && prm_ring == RID_W'(g)),
      .prm_size (prm_wdata[IDX_W:0]),
      .prm_thr  (prm_wdata[THR_LSB +: THR_W]),
      .lfp_we   (lfp_we && lfp_ring == RID_W'(g)),
      .lfp_idx  (lfp_idx),
      .cons_stb (cons_stb && cons_ring == RID_W'(g)),
      .short_o  (short_vec[g])
    );
  end

  rxp_pause_pacer #(.PT_W(PT_W), .QSHIFT(QSHIFT)) u_pacer (
    .clk        (clk),
    .rst        (rst),
    .en         (en_q),
    .short_any  (|short_vec),
    .ptv        (ptv_q),
    .pause_req  (pause_req),
    .pause_send (pause_send)
  );

  p_ptv_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    (en_q && ptv_we) |=> $stable(ptv_q));
endmodule

// File: tb/rx_pause_trigger_tb_top.sv
module rx_pause_trigger_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 0, prm_we = 0, ptv_we = 0, lfp_we = 0, cons_stb = 0;
  logic [31:0] ctl_wdata = '0, prm_wdata = '0;
  logic [2:0]  prm_ring = '0, lfp_ring = '0, cons_ring = '0;
  logic [15:0] ptv_wdata = '0;
  logic [7:0]  lfp_idx = '0;
  logic        pause_req, pause_send;
  logic [15:0] pause_time;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  rx_pause_trigger dut_i (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .prm_we(prm_we), .prm_ring(prm_ring), .prm_wdata(prm_wdata),
    .ptv_we(ptv_we), .ptv_wdata(ptv_wdata), .lfp_we(lfp_we),
    .lfp_ring(lfp_ring), .lfp_idx(lfp_idx), .cons_stb(cons_stb),
    .cons_ring(cons_ring), .pause_req(pause_req), .pause_send(pause_send),
    .pause_time(pause_time)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(); @(negedge clk); endtask

  task automatic wr_ctl(bit e);
    @(negedge clk); ctl_we = 1; ctl_wdata = 32'(e) << 14;
    @(negedge clk); ctl_we = 0;
  endtask
  task automatic wr_prm(int ring, int size, int thr);
    @(negedge clk); prm_we = 1; prm_ring = 3'(ring);
    prm_wdata = (32'(thr) << 24) | 32'(size);
    @(negedge clk); prm_we = 0;
  endtask
  task automatic wr_ptv(int v);
    @(negedge clk); ptv_we = 1; ptv_wdata = 16'(v);
    @(negedge clk); ptv_we = 0;
  endtask
  task automatic wr_lfp(int ring, int idx);
    @(negedge clk); lfp_we = 1; lfp_ring = 3'(ring); lfp_idx = 8'(idx);
    @(negedge clk); lfp_we = 0;
  endtask
  task automatic consume(int ring, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cons_stb = 1; cons_ring = 3'(ring);
    end
    @(negedge clk); cons_stb = 0;
  endtask

  task automatic t_reset();
    settle();
    chk("R1 req", 32'(pause_req), 0);
    chk("R1 send", 32'(pause_send), 0);
    chk("R1 time", 32'(pause_time), 4);
  endtask

  task automatic t_setup_init();
    wr_ptv(1);
    wr_prm(0, 32, 16);
    wr_prm(3, 8, 4);
    consume(3, 3);           // R4: tracked while disabled, ring3 index 3
    wr_ctl(1);               // R3: marks become 31 and 2
    settle();
    chk("R3 full after enable", 32'(pause_req), 0);
    chk("R2 pause time", 32'(pause_time), 1);
    // R1: rings of size 0 (e.g. ring5) would be short if active; req stays 0
  endtask

  task automatic t_threshold();
    int n;
    consume(0, 15); settle();  // free 16 == threshold
    chk("R5 equal not short", 32'(pause_req), 0);
    consume(0, 1); settle();   // free 15
    chk("R5 short raises req", 32'(pause_req), 1);
    chk("R7 first send", 32'(pause_send), 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!pause_send && n < 300);
    chk("R7 send interval", 32'(n), 65);
    chk("R7 req held", 32'(pause_req), 1);
  endtask

  task automatic t_frozen();
    wr_ptv(9);
    wr_prm(0, 32, 0);
    settle();
    chk("R2 ptv frozen", 32'(pause_time), 1);
    chk("R2 param frozen", 32'(pause_req), 1);
  endtask

  task automatic t_refill_wrap();
    wr_lfp(0, 0); settle();    // ring0 free (0-16) mod 32 = 16
    chk("R6 refill clears", 32'(pause_req), 0);
    consume(3, 4); settle();   // ring3 index 7, free 3
    chk("R5 other ring ORed", 32'(pause_req), 1);
    wr_lfp(3, 6); settle();    // free 7
    chk("R5 ring3 recovered", 32'(pause_req), 0);
    consume(3, 1); settle();   // index wraps to 0, free 6
    chk("R4 wrap no short", 32'(pause_req), 0);
    consume(3, 3); settle();   // index 3, free 3
    chk("R4 after wrap short", 32'(pause_req), 1);
    wr_lfp(3, 9); settle();    // out of range, ignored
    chk("R6 out of range ignored", 32'(pause_req), 1);
    wr_lfp(3, 1); settle();    // free (1-3) mod 8 = 6
    chk("R5 modulo distance", 32'(pause_req), 0);
  endtask

  task automatic t_disable();
    consume(3, 3); settle();   // index 6, free 3
    chk("R8 short before disable", 32'(pause_req), 1);
    wr_ctl(0); settle();
    chk("R8 req drops", 32'(pause_req), 0);
    chk("R8 send drops", 32'(pause_send), 0);
  endtask

  task automatic t_reprogram();
    wr_prm(0, 32, 20);         // ring0 index cleared
    wr_ctl(1); settle();       // ring0 free 31, ring3 mark 5 free 7
    chk("R3 re-enable full", 32'(pause_req), 0);
    consume(0, 11); settle();  // free 20
    chk("R2 new thr equal", 32'(pause_req), 0);
    consume(0, 1); settle();   // free 19
    chk("R2 new thr short", 32'(pause_req), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_setup_init();
    t_threshold();
    t_frozen();
    t_refill_wrap();
    t_disable();
    t_reprogram();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule